// File: doc/BRIEF.md
# GPIO Bank with Routed Summary Interrupt

This block holds a parameterised number of general-purpose pins. Every pin has its own configuration, data, interrupt-setup, status and routing registers, all reached through a simple memory-mapped port. The port has an address, a write strobe, write data and a read strobe. Pad inputs are resynchronised before any logic looks at them. Each pin can then detect either a level or a single-polarity edge.

A detected trigger reaches two places, and each has its own enable. The first is a sticky status flag that software clears by writing 1. The second is a per-pin pending term. The pending term only counts when the pin's routing code names the processor. All such pending terms are ORed into one registered summary interrupt line. To catch both edges, software flips the polarity bit between events.

Top module: `pinbank_irq`

## Requirements
- R1: After reset, every pin has output enable 0, driven value 0, interrupt setup 0, status 0 and routing code 7, and the summary interrupt is 0.
- R2: The per-pin window for pin p starts at byte address 0x1000 + 0x10*p. Bit 9 of the word at +0x0 drives `pad_oe[p]`. Bit 1 of the word at +0x4 drives `pad_out[p]`. Both read back from the same places.
- R3: Bit 0 of the word at +0x4 reads the pad input after a two-flop synchroniser. A pad change is not visible to a read whose strobe is issued in the same cycle as the change.
- R4: Read data appears on `rdata` in the cycle after `rd_en`. Addresses outside both windows, and pin indices at or above the pin count, read as 0.
- R5: The interrupt setup word at +0x8 has these fields: bit 0 enable, bit 1 polarity (1 = rising/high, 0 = falling/low), bit 2 mode (1 = edge, 0 = level) and bit 3 status enable. In edge mode, only a transition into the selected polarity sets status bit 0 of the word at +0xC, and only when bit 3 is set.
- R6: With status enable clear and enable set, a trigger still raises the summary interrupt, but the status bit stays 0.
- R7: Writing 1 to status bit 0 clears it. Writing 0 leaves it unchanged.
- R8: In level mode, status is set while the synchronised input equals the polarity bit. A clear issued while the level is still active is followed by the status being set again.
- R9: The summary interrupt is registered. It is 1 exactly one cycle after some pin has enable set, routing code 4, and an active trigger. Any routing code other than 4 keeps that pin off the line.
- R10: An edge pending term remains set after the input returns inactive, until a status clear write. A level pending term follows the input level.
- R11: The 3-bit routing code of pin p is read and written at byte address 0x0400 + 4*p.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW (16) | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wdata | input | DW (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | DW (32) | Read data, valid one cycle after `rd_en` |
| pad_in | input | NPINS (8) | Asynchronous pad input levels |
| pad_oe | output | NPINS (8) | Per-pin output enable |
| pad_out | output | NPINS (8) | Per-pin driven value |
| irq | output | 1 | Registered summary interrupt |

## Verification
The assertions rely on two assumptions about the inputs. First, `pad_in` is seen only through the synchroniser. Second, the enable, polarity and routing fields change only through writes, so a rising status bit can always be traced to the input level and setup fields of the cycle before. The bench meets this by changing the pads and register contents only on falling clock edges. Before each new setup it parks the pad at the inactive level for several cycles, so that no stale edge is present when a pin is enabled. It waits well past the synchroniser and the summary register before it samples.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;

  typedef struct packed {
    logic raw_en;    // bit 3: status latching enable
    logic edge_sel;  // bit 2: 1 edge, 0 level
    logic pol;       // bit 1: 1 rising/high, 0 falling/low
    logic en;        // bit 0: interrupt enable
  } icfg_t;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CFG,
    SEL_IO,
    SEL_ICFG,
    SEL_STAT,
    SEL_ROUTE
  } sel_e;

  localparam logic [2:0] ROUTE_CPU  = 3'd4;
  localparam logic [2:0] ROUTE_NONE = 3'd7;
  localparam int OE_BIT  = 9;
  localparam int OUT_BIT = 1;
  localparam int IN_BIT  = 0;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= '0;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pinbank_regdec.sv
module pinbank_regdec
  import pinbank_pkg::*;
#(
  parameter int NPINS  = 8,
  parameter int AW     = 16,
  parameter int PIDX_W = 3
) (
  input  logic [AW-1:0]     addr,
  output sel_e              sel,
  output logic [PIDX_W-1:0] pin
);

  localparam logic [AW-13:0] BANK_PAGE  = (AW-12)'(1);
  localparam logic [AW-11:0] ROUTE_PAGE = (AW-10)'(1);
  localparam logic [7:0]     NP8        = 8'(NPINS);

  logic unused_lsb;
  assign unused_lsb = ^addr[1:0];

  always_comb begin
    sel = SEL_NONE;
    pin = '0;
    if (addr[AW-1:12] == BANK_PAGE) begin
      if (addr[11:4] < NP8) begin
        pin = addr[4 +: PIDX_W];
        case (addr[3:2])
          2'd0:    sel = SEL_CFG;
          2'd1:    sel = SEL_IO;
          2'd2:    sel = SEL_ICFG;
          default: sel = SEL_STAT;
        endcase
      end
    end else if (addr[AW-1:10] == ROUTE_PAGE) begin
      if (addr[9:2] < NP8) begin
        pin = addr[2 +: PIDX_W];
        sel = SEL_ROUTE;
      end
    end
  end

endmodule

// File: rtl/pinbank_pin.sv
module pinbank_pin
  import pinbank_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we_cfg,
  input  logic       we_io,
  input  logic       we_icfg,
  input  logic       we_stat,
  input  logic       we_route,
  input  logic       wd_oe,
  input  logic       wd_out,
  input  logic [3:0] wd_icfg,
  input  logic [2:0] wd_route,
  input  logic       wd_clr,
  input  logic       lvl_in,
  output logic       oe_o,
  output logic       out_o,
  output icfg_t      icfg_o,
  output logic       stat_o,
  output logic [2:0] route_o,
  output logic       pend_o
);

  logic  oe_q, out_q, stat_q, hit_q, prev_q;
  icfg_t icfg_q;
  logic [2:0] route_q;

  logic active, edge_hit, lvl_hit, clr;
  logic stat_d, hit_d;

  always_comb begin
    active   = (lvl_in == icfg_q.pol);
    edge_hit = icfg_q.edge_sel & active & (prev_q != icfg_q.pol);
    lvl_hit  = ~icfg_q.edge_sel & active;
    clr      = we_stat & wd_clr;
    // an edge in the clearing cycle survives; a level clear wins for one cycle
    stat_d   = (icfg_q.raw_en & edge_hit) |
               (~clr & (stat_q | (icfg_q.raw_en & lvl_hit)));
    hit_d    = (icfg_q.en & edge_hit) | (~clr & hit_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_q    <= 1'b0;
      out_q   <= 1'b0;
      icfg_q  <= '0;
      route_q <= ROUTE_NONE;
      stat_q  <= 1'b0;
      hit_q   <= 1'b0;
      prev_q  <= 1'b0;
    end else begin
      if (we_cfg)   oe_q    <= wd_oe;
      if (we_io)    out_q   <= wd_out;
      if (we_icfg)  icfg_q  <= icfg_t'(wd_icfg);
      if (we_route) route_q <= wd_route;
      stat_q <= stat_d;
      hit_q  <= hit_d;
      prev_q <= lvl_in;
    end
  end

  assign oe_o    = oe_q;
  assign out_o   = out_q;
  assign icfg_o  = icfg_q;
  assign stat_o  = stat_q;
  assign route_o = route_q;
  assign pend_o  = icfg_q.en & (route_q == ROUTE_CPU) &
                   (icfg_q.edge_sel ? hit_q : active);

endmodule

// File: rtl/pinbank_irq.sv
module pinbank_irq
  import pinbank_pkg::*;
#(
  parameter int NPINS = 8,
  parameter int AW    = 16,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wdata,
  input  logic             rd_en,
  output logic [DW-1:0]    rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_out,
  output logic             irq
);

  localparam int PIDX_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  sel_e              sel;
  logic [PIDX_W-1:0] pin;
  logic [NPINS-1:0]  lvl_s;
  logic [NPINS-1:0]  stat_v, pend_v;
  icfg_t [NPINS-1:0] icfg_v;
  logic [NPINS-1:0][2:0] route_v;
  logic [DW-1:0]     rmux;
  logic              irq_q;
  logic [DW-1:0]     rdata_q;

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  pinbank_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pad_in),
    .q   (lvl_s)
  );

  pinbank_regdec #(.NPINS(NPINS), .AW(AW), .PIDX_W(PIDX_W)) u_dec (
    .addr (addr),
    .sel  (sel),
    .pin  (pin)
  );

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_pin
      logic hit_me;
      assign hit_me = wr_en && (pin == PIDX_W'(i));

      pinbank_pin u_pin (
        .clk      (clk),
        .rst      (rst),
        .we_cfg   (hit_me && sel == SEL_CFG),
        .we_io    (hit_me && sel == SEL_IO),
        .we_icfg  (hit_me && sel == SEL_ICFG),
        .we_stat  (hit_me && sel == SEL_STAT),
        .we_route (hit_me && sel == SEL_ROUTE),
        .wd_oe    (wdata[OE_BIT]),
        .wd_out   (wdata[OUT_BIT]),
        .wd_icfg  (wdata[3:0]),
        .wd_route (wdata[2:0]),
        .wd_clr   (wdata[0]),
        .lvl_in   (lvl_s[i]),
        .oe_o     (pad_oe[i]),
        .out_o    (pad_out[i]),
        .icfg_o   (icfg_v[i]),
        .stat_o   (stat_v[i]),
        .route_o  (route_v[i]),
        .pend_o   (pend_v[i])
      );
    end
  endgenerate

  always_comb begin
    rmux = '0;
    case (sel)
      SEL_CFG:   rmux[OE_BIT] = pad_oe[pin];
      SEL_IO: begin
        rmux[OUT_BIT] = pad_out[pin];
        rmux[IN_BIT]  = lvl_s[pin];
      end
      SEL_ICFG:  rmux[3:0] = icfg_v[pin];
      SEL_STAT:  rmux[0]   = stat_v[pin];
      SEL_ROUTE: rmux[2:0] = route_v[pin];
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      rdata_q <= rd_en ? rmux : '0;
      irq_q   <= |pend_v;
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;

endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk
  import pinbank_pkg::*;
#(
  parameter int NPINS = 8
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  irq,
  input logic [NPINS-1:0]      pend,
  input logic [NPINS-1:0]      stat,
  input icfg_t [NPINS-1:0]     icfg,
  input logic [NPINS-1:0][2:0] route,
  input logic [NPINS-1:0]      lvl
);

  // R9
  sum_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|pend) |=> irq);

  // R9
  sum_clr_chk: assert property (@(posedge clk) disable iff (rst)
    !(|pend) |=> !irq);

  genvar i;
  generate
    for (i = 0; i < NPINS; i++) begin : g_chk
      // R9
      route_gate_chk: assert property (@(posedge clk) disable iff (rst)
        pend[i] |-> (route[i] == ROUTE_CPU && icfg[i].en));

      // R6
      raw_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[i]) |-> $past(icfg[i].raw_en));

      // R5
      stat_pol_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat[i]) |-> ($past(lvl[i]) == $past(icfg[i].pol)));
    end
  endgenerate

endmodule

bind pinbank_irq pinbank_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .irq   (irq),
  .pend  (pend_v),
  .stat  (stat_v),
  .icfg  (icfg_v),
  .route (route_v),
  .lvl   (lvl_s)
);

// File: tb/pinbank_irq_test.sv
`timescale 1ns/1ps
module pinbank_irq_test;

  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [15:0]   addr = '0;
  logic          wr_en = 1'b0;
  logic [31:0]   wdata = '0;
  logic          rd_en = 1'b0;
  logic [31:0]   rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_oe, pad_out;
  logic          irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pinbank_irq #(.NPINS(NP), .AW(16), .DW(32)) uut (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .pad_in(pad_in), .pad_oe(pad_oe),
    .pad_out(pad_out), .irq(irq)
  );

  function automatic logic [15:0] a_cfg(int p);  return 16'h1000 + 16'(p*16);     endfunction
  function automatic logic [15:0] a_io(int p);   return 16'h1004 + 16'(p*16);     endfunction
  function automatic logic [15:0] a_icfg(int p); return 16'h1008 + 16'(p*16);     endfunction
  function automatic logic [15:0] a_stat(int p); return 16'h100C + 16'(p*16);     endfunction
  function automatic logic [15:0] a_rte(int p);  return 16'h0400 + 16'(p*4);      endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    idle(4);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pad_oe", {28'b0, pad_oe}, 0);
    chk("R1 pad_out", {28'b0, pad_out}, 0);
    for (int p = 0; p < NP; p++) begin
      rd(a_cfg(p), d);  chk("R1 cfg", d, 0);
      rd(a_io(p), d);   chk("R1 io", d, 0);
      rd(a_icfg(p), d); chk("R1 icfg", d, 0);
      rd(a_stat(p), d); chk("R1 status", d, 0);
      rd(a_rte(p), d);  chk("R1 route", d, 7);
    end

    // R2 output enable and driven value
    wr(a_cfg(2), 32'h200);
    chk("R2 pad_oe", {28'b0, pad_oe}, 32'b0100);
    rd(a_cfg(2), d); chk("R2 cfg readback", d, 32'h200);
    wr(a_io(1), 32'h2);
    chk("R2 pad_out", {28'b0, pad_out}, 32'b0010);
    rd(a_io(1), d); chk("R2 io readback", d, 32'h2);
    wr(a_cfg(2), 0); wr(a_io(1), 0);
    chk("R2 pad_oe off", {28'b0, pad_oe}, 0);

    // R3 synchronised input read
    @(negedge clk);
    pad_in[3] = 1'b1; addr = a_io(3); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk("R3 input not yet visible", rdata, 0);
    idle(3);
    rd(a_io(3), d); chk("R3 input visible", d, 1);
    pad_in[3] = 1'b0; idle(4);
    rd(a_io(3), d); chk("R3 input low", d, 0);

    // R4 unmapped addresses
    wr(a_rte(0), 5);
    rd(16'h1040, d); chk("R4 pin beyond count", d, 0);
    rd(16'h0410, d); chk("R4 route beyond count", d, 0);
    rd(16'h2000, d); chk("R4 outside window", d, 0);
    rd(16'h0000, d); chk("R4 low page", d, 0);
    // R11 route readback
    rd(a_rte(0), d); chk("R11 route readback", d, 5);
    wr(a_rte(0), 7);

    // sweep: pin x polarity x mode x status-enable
    for (int p = 0; p < NP; p++)
      for (int pol = 0; pol < 2; pol++)
        for (int ed = 0; ed < 2; ed++)
          for (int raw = 0; raw < 2; raw++) begin
            pad_in[p] = (pol == 0);
            idle(4);
            wr(a_rte(p), 4);
            wr(a_icfg(p), 32'(raw*8 + ed*4 + pol*2 + 1));
            wr(a_stat(p), 1);
            idle(3);
            rd(a_stat(p), d); chk("R5 idle status", d, 0);
            chk("R9 idle irq", {31'b0, irq}, 0);
            pad_in[p] = (pol != 0);
            idle(6);
            rd(a_stat(p), d); chk("R5/R6 status on trigger", d, 32'(raw));
            chk("R9 irq on trigger", {31'b0, irq}, 1);
            pad_in[p] = (pol == 0);
            idle(6);
            rd(a_stat(p), d); chk("R8 status stays latched", d, 32'(raw));
            chk("R10 irq after release", {31'b0, irq}, 32'(ed));
            wr(a_stat(p), 1);
            idle(3);
            rd(a_stat(p), d); chk("R7 status cleared", d, 0);
            chk("R10 irq after clear", {31'b0, irq}, 0);
            wr(a_icfg(p), 0);
            wr(a_rte(p), 7);
          end

    // R9 routing gate: level-high, raw enabled, on pin 3
    pad_in = '0; idle(4);
    wr(a_icfg(3), 32'hB);            // raw, level, high, enable
    wr(a_rte(3), 5);
    pad_in[3] = 1'b1; idle(6);
    chk("R9 route 5 blocks irq", {31'b0, irq}, 0);
    rd(a_stat(3), d); chk("R9 status independent of route", d, 1);
    wr(a_rte(3), 7); idle(3);
    chk("R9 route 7 blocks irq", {31'b0, irq}, 0);
    wr(a_rte(3), 4); idle(3);
    chk("R9 route 4 passes irq", {31'b0, irq}, 1);

    // R7 writing 0 leaves status
    wr(a_stat(3), 0); idle(2);
    rd(a_stat(3), d); chk("R7 write 0 no effect", d, 1);

    // R8 clear while level still active re-sets
    wr(a_stat(3), 1); idle(2);
    rd(a_stat(3), d); chk("R8 status re-set while active", d, 1);
    pad_in[3] = 1'b0; idle(4);
    wr(a_stat(3), 1); idle(2);
    rd(a_stat(3), d); chk("R8 clear holds once inactive", d, 0);
    chk("R10 level irq follows input", {31'b0, irq}, 0);

    // R6 edge with status disabled on pin 0, falling polarity
    pad_in[0] = 1'b1; idle(4);
    wr(a_rte(0), 4);
    wr(a_icfg(0), 32'h5);            // edge, low, enable
    pad_in[0] = 1'b0; idle(6);
    chk("R6 irq without status", {31'b0, irq}, 1);
    rd(a_stat(0), d); chk("R6 status stays 0", d, 0);
    wr(a_stat(0), 1); idle(3);
    chk("R10 clear drops edge pending", {31'b0, irq}, 0);

    done = 1;
    summary();
    $finish;
  end

endmodule